// File: doc/BRIEF.md
# Three-Wire Serial Control Register Slave

This block is the slave end of a three-wire control port. The port has an active-low frame enable, a serial clock and one data line that is shared by both directions. A host sends one 16-clock frame each time it holds the enable low. The first byte is an address byte. Its top bit selects read or write, and the other seven bits name a register. The second byte is data. In a write frame the host sends the data byte. In a read frame the slave sends it back, MSB first.

The register bank controls an optical front-end receiver. One control register holds a power-mode field, a transimpedance range field and a channel select. Three 8-bit gain codes follow, one per wavelength channel. The block decodes these into a sleep flag, the range code, the channel code and the gain code of the selected channel.

A static strap places the bank at offsets 00h–0Fh or 10h–1Fh. This lets two slaves share one bus. The port pins are oversampled by the block clock, which must run at least about ten times faster than the serial clock. The shared data line is split into an input, an output and an output enable; the pad tristate lies outside the block.

Top module: `sio_ctl_slave`

## Requirements
- R1: After reset the block reports sleep_o=1, range_o=00, chan_o=00 and gain_o=00h, and it keeps sdio_oe_o low.
- R2: A write to offset 0 stores its bits [7:6] as the power mode, [5:4] as the range and [3:2] as the channel. A read of offset 0 returns these fields with bits [1:0] as zero.
- R3: Writes to offsets 1, 2 and 3 set the 8-bit gain codes of channels 1, 2 and 3. Reading those offsets returns the stored codes.
- R4: gain_o carries the gain code of the channel that chan_o names (01, 10 or 11). When chan_o is 00, gain_o is 00h.
- R5: sleep_o is low only when the power mode is 11. Modes 10, 01 and 00 all give sleep_o=1.
- R6: In a read frame the slave drives sdio_o with data bits D7..D0 during clocks 9 to 16. Each new bit is set up after a falling clock edge. sdio_oe_o stays low during the address byte and drops within a few block clocks after the enable rises.
- R7: The address byte must have bits [6:5]=00 and bit 4 equal to grp_sel_i, or the frame is ignored: no register changes and sdio_oe_o stays low. Bits [3:0] give the offset.
- R8: Offsets 4h–Dh are unused and offsets Eh and Fh are fixed test registers. Writes to any of them have no effect, and reads of them return 00h.
- R9: A frame whose enable rises before the 16th rising clock edge changes no register. The next frame decodes normally from its first bit.
- R10: Address-byte bit 7 set to 1 marks a read and set to 0 marks a write. A read frame leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n_i | input | 1 | Frame enable from host, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdio_i | input | 1 | Data line as seen from the pad |
| grp_sel_i | input | 1 | Strap: 0 answers 00h–0Fh, 1 answers 10h–1Fh |
| sdio_o | output | 1 | Read data toward the pad |
| sdio_oe_o | output | 1 | Pad output enable for sdio_o |
| sleep_o | output | 1 | High unless power mode is 11 |
| range_o | output | 2 | Transimpedance range code |
| chan_o | output | 2 | Selected wavelength channel code |
| gain_o | output | 8 | Gain code of the selected channel |

## Verification
The assertions check the following on every cycle:
- The decoded outputs move only in the cycle after an internal write strobe.
- No write strobe fires while the data line is driven.
- The driver turns on only while the synchronised clock is low.
- The driven bit stays steady while the clock is high.
- The driver is off once the enable has been idle for four cycles.
- A channel code of 00 gives a zero gain.

Only the bench scenarios can show the following:
- Which address and data values reach which register.
- Read data order.
- The effect of the group strap.
- Aborted frames.
- Writes to reserved offsets having no effect.

// File: rtl/sio_ctl_pkg.sv
package sio_ctl_pkg;

    localparam int OFF_W   = 4;
    localparam int CTL_W   = 6;
    localparam logic [1:0] PWR_AWAKE = 2'b11;

    typedef struct packed {
        logic [1:0] pwr;
        logic [1:0] rng;
        logic [1:0] chan;
    } ctl_t;

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sio_frame.sv
module sio_frame
    import sio_ctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n_s,
    input  logic              sclk_s,
    input  logic              sdio_s,
    input  logic              grp_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [OFF_W-1:0]  rd_off_o,
    output logic              wr_en_o,
    output logic [OFF_W-1:0]  wr_off_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              sdio_o,
    output logic              sdio_oe_o
);

    localparam int FRAME = 2 * DATA_W;
    localparam int CNT_W = $clog2(FRAME + 1);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic              is_rd;
        logic              hit;
        logic [OFF_W-1:0]  off;
        logic              drive;
        logic [DATA_W-1:0] tx;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } fr_t;

    fr_t fr_d, fr_q;
    logic rise, fall;
    logic [DATA_W-1:0] shin;

    always_comb begin
        fr_d           = fr_q;
        fr_d.wr        = 1'b0;
        fr_d.sclk_prev = sclk_s;
        rise = sclk_s & ~fr_q.sclk_prev;
        fall = ~sclk_s & fr_q.sclk_prev;
        shin = {fr_q.shreg[DATA_W-2:0], sdio_s};

        if (en_n_s) begin
            fr_d.cnt   = '0;
            fr_d.drive = 1'b0;
            fr_d.hit   = 1'b0;
            fr_d.is_rd = 1'b0;
        end else if (rise && fr_q.cnt < CNT_W'(FRAME)) begin
            fr_d.shreg = shin;
            fr_d.cnt   = fr_q.cnt + 1'b1;
            if (fr_q.cnt == CNT_W'(DATA_W - 1)) begin
                fr_d.is_rd = shin[DATA_W-1];
                fr_d.hit   = (shin[DATA_W-2:OFF_W+1] == '0) && (shin[OFF_W] == grp_i);
                fr_d.off   = shin[OFF_W-1:0];
            end
            if (fr_q.cnt == CNT_W'(FRAME - 1) && fr_q.hit && !fr_q.is_rd) begin
                fr_d.wr    = 1'b1;
                fr_d.wdata = shin;
            end
        end else if (fall) begin
            if (fr_q.cnt == CNT_W'(DATA_W) && fr_q.hit && fr_q.is_rd && !fr_q.drive) begin
                fr_d.drive = 1'b1;
                fr_d.tx    = rd_data_i;
            end else if (fr_q.drive && fr_q.cnt < CNT_W'(FRAME)) begin
                fr_d.tx = {fr_q.tx[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign rd_off_o  = fr_q.off;
    assign wr_en_o   = fr_q.wr;
    assign wr_off_o  = fr_q.off;
    assign wr_data_o = fr_q.wdata;
    assign sdio_o    = fr_q.tx[DATA_W-1];
    assign sdio_oe_o = fr_q.drive;

endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
    import sio_ctl_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter int              NCH      = 3,
    parameter logic [DATA_W-1:0] GAIN_RST = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              sleep_o,
    output logic [1:0]        range_o,
    output logic [1:0]        chan_o,
    output logic [DATA_W-1:0] gain_o
);

    typedef struct packed {
        ctl_t                       ctl;
        logic [NCH-1:0][DATA_W-1:0] gain;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (wr_en_i) begin
            if (wr_off_i == '0) bk_d.ctl = ctl_t'(wr_data_i[DATA_W-1 -: CTL_W]);
            for (int c = 0; c < NCH; c++) begin
                if (wr_off_i == OFF_W'(c + 1)) bk_d.gain[c] = wr_data_i;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_off_i == '0) rd_data_o = {bk_q.ctl, {(DATA_W-CTL_W){1'b0}}};
        for (int c = 0; c < NCH; c++) begin
            if (rd_off_i == OFF_W'(c + 1)) rd_data_o = bk_q.gain[c];
        end
    end

    always_comb begin
        gain_o = '0;
        for (int c = 0; c < NCH; c++) begin
            if (bk_q.ctl.chan == 2'(c + 1)) gain_o = bk_q.gain[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.ctl  <= '0;
            bk_q.gain <= {NCH{GAIN_RST}};
        end else begin
            bk_q <= bk_d;
        end
    end

    assign sleep_o = (bk_q.ctl.pwr != PWR_AWAKE);
    assign range_o = bk_q.ctl.rng;
    assign chan_o  = bk_q.ctl.chan;

endmodule

// File: rtl/sio_ctl_slave.sv
module sio_ctl_slave
    import sio_ctl_pkg::*;
#(
    parameter int              DATA_W      = 8,
    parameter int              SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] GAIN_RST  = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n_i,
    input  logic              sclk_i,
    input  logic              sdio_i,
    input  logic              grp_sel_i,
    output logic              sdio_o,
    output logic              sdio_oe_o,
    output logic              sleep_o,
    output logic [1:0]        range_o,
    output logic [1:0]        chan_o,
    output logic [DATA_W-1:0] gain_o
);

    logic [2:0]        pins_s;
    logic              en_n_s, sclk_s, sdio_s;
    logic [DATA_W-1:0] rd_data;
    logic [OFF_W-1:0]  rd_off, wr_off;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;

    sio_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({en_n_i, sclk_i, sdio_i}),
        .sync_o (pins_s)
    );

    assign {en_n_s, sclk_s, sdio_s} = pins_s;

    sio_frame #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n_s    (en_n_s),
        .sclk_s    (sclk_s),
        .sdio_s    (sdio_s),
        .grp_i     (grp_sel_i),
        .rd_data_i (rd_data),
        .rd_off_o  (rd_off),
        .wr_en_o   (wr_en),
        .wr_off_o  (wr_off),
        .wr_data_o (wr_data),
        .sdio_o    (sdio_o),
        .sdio_oe_o (sdio_oe_o)
    );

    sio_regbank #(.DATA_W(DATA_W), .GAIN_RST(GAIN_RST)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_off_i  (wr_off),
        .wr_data_i (wr_data),
        .rd_off_i  (rd_off),
        .rd_data_o (rd_data),
        .sleep_o   (sleep_o),
        .range_o   (range_o),
        .chan_o    (chan_o),
        .gain_o    (gain_o)
    );

endmodule

// File: rtl/sio_ctl_chk.sv
module sio_ctl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_n_i,
    input logic              sclk_s,
    input logic              wr_en,
    input logic              sdio_o,
    input logic              sdio_oe_o,
    input logic              sleep_o,
    input logic [1:0]        range_o,
    input logic [1:0]        chan_o,
    input logic [DATA_W-1:0] gain_o
);

    logic [2:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           idle_cnt <= '0;
        else if (!en_n_i)     idle_cnt <= '0;
        else if (idle_cnt != 3'd7) idle_cnt <= idle_cnt + 1'b1;
    end

    // R6: driver released once the enable has been idle for a while
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt >= 3'd4 |-> !sdio_oe_o);

    // R6: driver turns on only after a falling serial clock edge
    p_oe_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe_o) |-> !sclk_s);

    // R6: driven bit holds while the serial clock is high
    p_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe_o && $past(sdio_oe_o) && sclk_s && $past(sclk_s)) |-> $stable(sdio_o));

    // R9: outputs move only right after a committed write
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable({sleep_o, range_o, chan_o, gain_o}));

    // R10: a write commit never happens while the line is driven
    p_no_wr_in_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sdio_oe_o);

    // R4: no channel selected gives zero gain
    p_zero_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_o == 2'b00 |-> gain_o == '0);

endmodule

bind sio_ctl_slave sio_ctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_n_i    (en_n_i),
    .sclk_s    (sclk_s),
    .wr_en     (wr_en),
    .sdio_o    (sdio_o),
    .sdio_oe_o (sdio_oe_o),
    .sleep_o   (sleep_o),
    .range_o   (range_o),
    .chan_o    (chan_o),
    .gain_o    (gain_o)
);

// File: tb/sio_ctl_slave_tb.sv
module sio_ctl_slave_tb;

    localparam int HALF = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0, grp = 1'b0;
    logic       sdio_out, sdio_oe, sleep;
    logic [1:0] rng, chan;
    logic [7:0] gain;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0] m_ctl;
    logic [7:0] m_gain [3];

    always #2 clk = ~clk;

    sio_ctl_slave u_dut (
        .clk(clk), .rst_n(rst_n), .en_n_i(en_n), .sclk_i(sclk), .sdio_i(sdio_in),
        .grp_sel_i(grp), .sdio_o(sdio_out), .sdio_oe_o(sdio_oe), .sleep_o(sleep),
        .range_o(rng), .chan_o(chan), .gain_o(gain)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit hit(input logic [7:0] a, input logic g);
        return (a[6:5] == 2'b00) && (a[4] == g);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [3:0] off);
        case (off)
            4'd0: return m_ctl;
            4'd1: return m_gain[0];
            4'd2: return m_gain[1];
            4'd3: return m_gain[2];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_gain();
        if (m_ctl[3:2] == 2'b00) return 8'h00;
        return m_gain[m_ctl[3:2] - 1];
    endfunction

    task automatic check_outs(input string req);
        chk(sleep == (m_ctl[7:6] != 2'b11), req, sleep, m_ctl[7:6] != 2'b11);
        chk(rng == m_ctl[5:4], req, rng, m_ctl[5:4]);
        chk(chan == m_ctl[3:2], req, chan, m_ctl[3:2]);
        chk(gain == exp_gain(), req, gain, exp_gain());
    endtask

    // host frame; nclk < 16 aborts
    task automatic frame(input logic [7:0] a, input logic [7:0] d, input int nclk,
                         input string req);
        logic [7:0] rbit = 8'h00;
        bit oe_all = 1, oe_addr = 0, oe_any = 0;
        bit is_rd = a[7];
        bit h = hit(a, grp);
        @(negedge clk);
        en_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            sdio_in = (i < 8) ? a[7-i] : (is_rd ? 1'b0 : d[15-i]);
            repeat (HALF) @(negedge clk);
            if (i < 8) begin
                if (sdio_oe) oe_addr = 1;
            end else begin
                rbit[15-i] = sdio_out;
                if (!sdio_oe) oe_all = 0;
                if (sdio_oe) oe_any = 1;
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        en_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(!oe_addr, "R6 addr phase undriven", oe_addr, 0);
        chk(!sdio_oe, "R6 release", sdio_oe, 0);
        if (nclk == 16 && !is_rd && h) begin
            if (a[3:0] == 4'd0) m_ctl = d & 8'hFC;
            else if (a[3:0] >= 4'd1 && a[3:0] <= 4'd3) m_gain[a[3:0]-1] = d;
        end
        if (is_rd && nclk == 16 && h) begin
            chk(oe_all, {req, " R6 drive"}, oe_all, 1);
            chk(rbit == exp_rd(a[3:0]), {req, " R10 readback"}, rbit, exp_rd(a[3:0]));
        end
        if (!h) chk(!oe_any, {req, " R7 foreign undriven"}, oe_any, 0);
        check_outs(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_ctl = 8'h00;
        for (int c = 0; c < 3; c++) m_gain[c] = 8'h80;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(sleep == 1'b1, "R1 sleep", sleep, 1);
        chk(rng == 2'b00, "R1 range", rng, 0);
        chk(chan == 2'b00, "R1 chan", chan, 0);
        chk(gain == 8'h00, "R1 gain", gain, 0);
        chk(sdio_oe == 1'b0, "R1 oe", sdio_oe, 0);

        // R2 control fields, low bits read zero
        frame(8'h00, 8'hD7, 16, "R2");
        chk(sleep == 1'b0 && rng == 2'b01 && chan == 2'b01, "R2 fields",
            {sleep, rng, chan}, 5'b00101);
        frame(8'h80, 8'h00, 16, "R2");
        // R3 gains
        frame(8'h01, 8'h11, 16, "R3");
        frame(8'h02, 8'h22, 16, "R3");
        frame(8'h03, 8'h33, 16, "R3");
        for (int o = 1; o <= 3; o++) frame(8'h80 | 8'(o), 8'h00, 16, "R3");
        chk(gain == 8'h11, "R4 chan1", gain, 8'h11);
        // R4 channel mux
        frame(8'h00, 8'hF8, 16, "R4");
        chk(gain == 8'h22, "R4 chan2", gain, 8'h22);
        frame(8'h00, 8'hEC, 16, "R4");
        chk(gain == 8'h33, "R4 chan3", gain, 8'h33);
        frame(8'h00, 8'hE0, 16, "R4");
        chk(gain == 8'h00, "R4 chan0", gain, 0);
        // R5 sleep decode
        frame(8'h00, 8'hA4, 16, "R5");
        chk(sleep == 1'b1, "R5 mode10", sleep, 1);
        frame(8'h00, 8'h44, 16, "R5");
        chk(sleep == 1'b1, "R5 mode01", sleep, 1);
        frame(8'h00, 8'hC8, 16, "R5");
        chk(sleep == 1'b0, "R5 mode11", sleep, 0);
        // R8 reserved and test offsets
        frame(8'h05, 8'hFF, 16, "R8");
        frame(8'h0E, 8'hFF, 16, "R8");
        frame(8'h0F, 8'hA5, 16, "R8");
        frame(8'h85, 8'h00, 16, "R8");
        frame(8'h8E, 8'h00, 16, "R8");
        frame(8'h8F, 8'h00, 16, "R8");
        // R7 group strap
        frame(8'h12, 8'h99, 16, "R7");
        frame(8'h92, 8'h00, 16, "R7");
        frame(8'h42, 8'h77, 16, "R7");
        frame(8'h82, 8'h00, 16, "R7");
        grp = 1'b1;
        frame(8'h92, 8'h00, 16, "R7");
        frame(8'h13, 8'h5A, 16, "R7");
        frame(8'h03, 8'h66, 16, "R7");
        frame(8'h93, 8'h00, 16, "R7");
        grp = 1'b0;
        frame(8'h83, 8'h00, 16, "R7");
        // R9 aborted frames
        frame(8'h01, 8'hEE, 10, "R9");
        frame(8'h01, 8'hEE, 15, "R9");
        frame(8'h81, 8'h00, 16, "R9");
        frame(8'h00, 8'h00, 3, "R9");
        frame(8'h80, 8'h00, 16, "R9");
        // random mix
        for (int n = 0; n < 40; n++) begin
            logic [7:0] a, d;
            int nc;
            a = 8'($urandom_range(0, 31));
            if ($urandom_range(0, 9) == 0) a[6:5] = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 2) == 0) a[3:0] = 4'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) a[7] = 1'b1;
            d = 8'($urandom);
            nc = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 15)) : 16;
            if ($urandom_range(0, 9) == 0) grp = ~grp;
            frame(a, d, nc, "R10 random");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule